// File: doc/BRIEF.md
# Load-Use and Branch Stall Counter

This unit does hazard accounting for a simple in-order core with sixteen general registers. The core presents each retired instruction as a descriptor. A descriptor carries an instruction class, two optional source register numbers, each with a valid flag, a destination register number and a branch-taken flag. The unit does not stall anything itself. It keeps a record of which register the previous instruction loaded. From that record it accumulates the cycles the pipeline loses to load-use hazards and to taken control transfers. It also counts taken and not-taken control transfers.

A load marks its destination as pending. Only the next valid descriptor sees that mark; after that descriptor the record is replaced. Every source operand that reads the pending register costs two cycles, counted separately for each operand. A taken control transfer costs two more cycles, and these go to a separate counter. All four counters are read in parallel. They saturate at their maximum value and clear on reset or on a synchronous clear.

Top module: `hazard_stall_counter`

## Requirements
- R1: After an active-low reset, or in the cycle after `clear` is high, all four counters read zero and no register is pending.
- R2: A valid descriptor of class 4 (load) makes its destination register pending for the next valid descriptor only. Any valid descriptor replaces the pending record: load sets exactly its destination, and every other class leaves nothing pending.
- R3: For class 0 (execute), 1 (compare) and 2 (multiply-accumulate), each valid source that names the pending register adds 2 to `load_stall_cnt`.
- R4: When both sources name the same pending register, the charge is 4: one charge for each operand.
- R5: A source whose valid flag is low is never checked against the pending register.
- R6: Class 3 (control transfer) checks source A only, using the 2-cycle rule. Source B is ignored.
- R7: A class 3 descriptor with `br_taken` high adds 2 to `branch_stall_cnt` and 1 to `taken_cnt`. With `br_taken` low it adds 1 to `not_taken_cnt` only.
- R8: Class 5 (store), class 4 (load) and the unused codes 6 and 7 add no stall charge, even when a source names the pending register.
- R9: While `ins_valid` is low, no counter changes and the pending record is held.
- R10: Each counter is `CNT_W` bits wide (default 32). It sticks at its all-ones value instead of wrapping.
- R11: Counters update on the clock edge that samples the descriptor. The new values are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear of counters and pending record |
| ins_valid | input | 1 | Descriptor present this cycle |
| ins_class | input | 3 | Instruction class code |
| src_a | input | 4 | Source A register number |
| src_a_vld | input | 1 | Source A present |
| src_b | input | 4 | Source B register number |
| src_b_vld | input | 1 | Source B present |
| dst | input | 4 | Destination register number |
| br_taken | input | 1 | Control transfer was taken |
| load_stall_cnt | output | CNT_W | Accumulated load-use stall cycles |
| branch_stall_cnt | output | CNT_W | Accumulated taken-branch stall cycles |
| taken_cnt | output | CNT_W | Taken control transfers |
| not_taken_cnt | output | CNT_W | Not-taken control transfers |

## Verification
Saturation is the hardest case to reach from the ports. A 32-bit counter that grows by at most four per descriptor would need billions of cycles to reach its limit. The bench therefore drives a second instance, built with 4-bit counters, from the same stimulus. That instance reaches its ceiling after a few taken branches and a few double-operand load-use pairs, and the bench then confirms that it holds there. The one-instruction reach of the pending record is probed by placing consumers directly after a load, two descriptors after a load, and after idle gaps.

// File: rtl/hsc_pkg.sv
`timescale 1ns/1ps
// Shared class encoding and sizing for the hazard stall counter.
// Assumes the class field is three bits wide; codes 6 and 7 are unused.
package hsc_pkg;
    localparam int NUM_REGS = 16;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int CLASS_W  = 3;
    localparam int INC_W    = 3;   // widest increment is 4
    localparam int NUM_CNT  = 4;

    typedef enum logic [CLASS_W-1:0] {
        CLS_EXEC  = 3'd0,
        CLS_CMP   = 3'd1,
        CLS_MAC   = 3'd2,
        CLS_CTI   = 3'd3,
        CLS_LOAD  = 3'd4,
        CLS_STORE = 3'd5
    } hsc_class_e;
endpackage

// File: rtl/hsc_hazard.sv
`timescale 1ns/1ps
// Holds a one-instruction pending-load record and reports how many
// source operands of the current descriptor read a pending register.
// Assumes one descriptor per cycle at most; clear takes priority.
module hsc_hazard
    import hsc_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    localparam int RW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               ins_valid,
    input  logic [CLASS_W-1:0] ins_class,
    input  logic [RW-1:0]      src_a,
    input  logic               src_a_vld,
    input  logic [RW-1:0]      src_b,
    input  logic               src_b_vld,
    input  logic [RW-1:0]      dst,
    output logic [1:0]         hit_cnt
);
    logic [NREG-1:0] pend_q;
    logic            chk_a, chk_b, hit_a, hit_b;
    logic            is_alu;

    // Decide which operands take part in the load-use check.
    always_comb begin
        is_alu = (ins_class == CLS_EXEC) || (ins_class == CLS_CMP) ||
                 (ins_class == CLS_MAC);
        chk_a  = ins_valid && src_a_vld && (is_alu || ins_class == CLS_CTI);
        chk_b  = ins_valid && src_b_vld && is_alu;
        hit_a  = chk_a && pend_q[src_a];
        hit_b  = chk_b && pend_q[src_b];
        hit_cnt = {1'b0, hit_a} + {1'b0, hit_b};
    end

    // Replace the pending record with each valid descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= '0;
        end else if (ins_valid) begin
            pend_q <= (ins_class == CLS_LOAD) ? (NREG'(1) << dst) : '0;
        end
    end

    // R2
    pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_q));

    // R5
    invalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt == 2'd2) |-> (src_a_vld && src_b_vld));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !clear) |=> $stable(pend_q));
endmodule

// File: rtl/hsc_sat_cnt.sv
`timescale 1ns/1ps
// Saturating accumulator: adds a small increment each cycle and sticks
// at all ones. Assumes W is at least the increment width.
module hsc_sat_cnt #(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  cnt
);
    localparam logic [W-1:0] MAX_V = '1;
    logic [W:0] sum;

    // Form the widened sum so a carry-out marks overflow.
    always_comb sum = {1'b0, cnt} + (W+1)'(inc);

    // Accumulate with saturation; reset and clear zero the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (sum[W])   cnt <= MAX_V;
        else               cnt <= sum[W-1:0];
    end

    // R10
    never_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (cnt >= $past(cnt)));

    // R10
    stick_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX_V && !clr) |=> (cnt == MAX_V));

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/hazard_stall_counter.sv
`timescale 1ns/1ps
// Hazard stall accounting for an in-order core: load-use and taken-branch
// penalty cycles plus taken / not-taken counts. Assumes descriptors arrive
// at most one per cycle, already decoded.
module hazard_stall_counter
    import hsc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               ins_valid,
    input  logic [CLASS_W-1:0] ins_class,
    input  logic [REG_W-1:0]   src_a,
    input  logic               src_a_vld,
    input  logic [REG_W-1:0]   src_b,
    input  logic               src_b_vld,
    input  logic [REG_W-1:0]   dst,
    input  logic               br_taken,
    output logic [CNT_W-1:0]   load_stall_cnt,
    output logic [CNT_W-1:0]   branch_stall_cnt,
    output logic [CNT_W-1:0]   taken_cnt,
    output logic [CNT_W-1:0]   not_taken_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [INC_W-1:0] PENALTY = INC_W'(2);

    logic [1:0]       hit_cnt;
    logic             is_cti;
    logic [INC_W-1:0] inc_vec [NUM_CNT];
    logic [CNT_W-1:0] cnt_vec [NUM_CNT];

    hsc_hazard #(.NREG(NUM_REGS)) u_hazard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .ins_valid (ins_valid),
        .ins_class (ins_class),
        .src_a     (src_a),
        .src_a_vld (src_a_vld),
        .src_b     (src_b),
        .src_b_vld (src_b_vld),
        .dst       (dst),
        .hit_cnt   (hit_cnt)
    );

    // Build the per-counter increments for this descriptor.
    always_comb begin
        is_cti     = ins_valid && (ins_class == CLS_CTI);
        inc_vec[0] = INC_W'(hit_cnt) * PENALTY;
        inc_vec[1] = (is_cti && br_taken) ? PENALTY : '0;
        inc_vec[2] = INC_W'(is_cti && br_taken);
        inc_vec[3] = INC_W'(is_cti && !br_taken);
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        hsc_sat_cnt #(.W(CNT_W), .IW(INC_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear),
            .inc   (inc_vec[i]),
            .cnt   (cnt_vec[i])
        );
    end

    assign load_stall_cnt   = cnt_vec[0];
    assign branch_stall_cnt = cnt_vec[1];
    assign taken_cnt        = cnt_vec[2];
    assign not_taken_cnt    = cnt_vec[3];

    // R7
    non_cti_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(ins_valid && ins_class == CLS_CTI)) |=>
            ($stable(taken_cnt) && $stable(not_taken_cnt) && $stable(branch_stall_cnt)));

    // R7
    taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && ins_valid && ins_class == CLS_CTI && br_taken && taken_cnt != CNT_MAX)
            |=> (taken_cnt == $past(taken_cnt) + CNT_W'(1)) && $stable(not_taken_cnt));

    // R8
    store_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && ins_valid && ins_class == CLS_STORE) |=> $stable(load_stall_cnt));
endmodule

// File: tb/hazard_stall_counter_bench.sv
`timescale 1ns/1ps
module hazard_stall_counter_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n, clear, ins_valid, src_a_vld, src_b_vld, br_taken;
    logic [2:0] ins_class;
    logic [3:0] src_a, src_b, dst;
    logic [31:0] ls, bs, tk, nt;
    logic [3:0]  s_ls, s_bs, s_tk, s_nt;

    hazard_stall_counter u_hazard_stall_counter (
        .clk(clk), .rst_n(rst_n), .clear(clear), .ins_valid(ins_valid),
        .ins_class(ins_class), .src_a(src_a), .src_a_vld(src_a_vld),
        .src_b(src_b), .src_b_vld(src_b_vld), .dst(dst), .br_taken(br_taken),
        .load_stall_cnt(ls), .branch_stall_cnt(bs), .taken_cnt(tk), .not_taken_cnt(nt));

    hazard_stall_counter #(.CNT_W(4)) u_sat (
        .clk(clk), .rst_n(rst_n), .clear(clear), .ins_valid(ins_valid),
        .ins_class(ins_class), .src_a(src_a), .src_a_vld(src_a_vld),
        .src_b(src_b), .src_b_vld(src_b_vld), .dst(dst), .br_taken(br_taken),
        .load_stall_cnt(s_ls), .branch_stall_cnt(s_bs), .taken_cnt(s_tk), .not_taken_cnt(s_nt));

    typedef struct {
        longint w[4];
        longint s[4];
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    longint m_w[4], m_s[4];
    logic [15:0] m_pend;
    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    function automatic longint sat(longint v, longint inc, longint maxv);
        return (v + inc > maxv) ? maxv : v + inc;
    endfunction

    // Driver: apply one cycle of inputs, advance the model, push expectation.
    task automatic drive(input logic v, input logic [2:0] c, input logic [3:0] a,
                         input logic av, input logic [3:0] b, input logic bv,
                         input logic [3:0] d, input logic t, input logic clr,
                         input string tag);
        exp_t e;
        longint inc[4];
        int hits;
        @(negedge clk);
        ins_valid = v; ins_class = c; src_a = a; src_a_vld = av;
        src_b = b; src_b_vld = bv; dst = d; br_taken = t; clear = clr;
        for (int i = 0; i < 4; i++) inc[i] = 0;
        if (clr) begin
            for (int i = 0; i < 4; i++) begin m_w[i] = 0; m_s[i] = 0; end
            m_pend = '0;
        end else if (v) begin
            hits = 0;
            if ((c <= 3'd3) && av && m_pend[a]) hits++;
            if ((c <= 3'd2) && bv && m_pend[b]) hits++;
            inc[0] = 2 * hits;
            if (c == 3'd3) begin
                if (t) begin inc[1] = 2; inc[2] = 1; end
                else inc[3] = 1;
            end
            for (int i = 0; i < 4; i++) begin
                m_w[i] = sat(m_w[i], inc[i], 64'hFFFF_FFFF);
                m_s[i] = sat(m_s[i], inc[i], 15);
            end
            m_pend = (c == 3'd4) ? (16'd1 << d) : 16'd0;
        end
        e.w = m_w; e.s = m_s; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 3'd0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic load(input logic [3:0] d);
        drive(1'b1, 3'd4, 4'd0, 1'b0, 4'd0, 1'b0, d, 1'b0, 1'b0, "R2");
    endtask

    task automatic cmp_one(input longint act, input longint exp, input string tag,
                           input string name);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
        end
    endtask

    // Monitor: after each rising edge has settled, compare the oldest item.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                cmp_one(longint'(ls), e.w[0], e.tag, "load_stall");
                cmp_one(longint'(bs), e.w[1], e.tag, "branch_stall");
                cmp_one(longint'(tk), e.w[2], e.tag, "taken");
                cmp_one(longint'(nt), e.w[3], e.tag, "not_taken");
                cmp_one(longint'(s_ls), e.s[0], {e.tag, " R10"}, "sat_load_stall");
                cmp_one(longint'(s_bs), e.s[1], {e.tag, " R10"}, "sat_branch_stall");
                cmp_one(longint'(s_tk), e.s[2], {e.tag, " R10"}, "sat_taken");
                cmp_one(longint'(s_nt), e.s[3], {e.tag, " R10"}, "sat_not_taken");
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_w[i] = 0; m_s[i] = 0; end
        m_pend = '0;
        rst_n = 1'b0; clear = 1'b0; ins_valid = 1'b0; ins_class = '0;
        src_a = '0; src_b = '0; dst = '0; src_a_vld = 1'b0; src_b_vld = 1'b0;
        br_taken = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset");
        // R3 / R11: consumer right after a load on source A
        load(4'd3);
        drive(1, 3'd0, 4'd3, 1, 4'd0, 1, 4'd0, 0, 0, "R3 R11");
        // R2: second consumer after the load sees nothing
        drive(1, 3'd0, 4'd3, 1, 4'd0, 0, 4'd0, 0, 0, "R2");
        // R4: both sources on the pending register
        load(4'd5);
        drive(1, 3'd1, 4'd5, 1, 4'd5, 1, 4'd0, 0, 0, "R4");
        // R5: invalid source A, valid source B; then both invalid
        load(4'd7);
        drive(1, 3'd2, 4'd7, 0, 4'd7, 1, 4'd0, 0, 0, "R5");
        load(4'd7);
        drive(1, 3'd2, 4'd7, 0, 4'd7, 0, 4'd0, 0, 0, "R5");
        // R6 / R7: control transfer ignores source B; taken path
        load(4'd2);
        drive(1, 3'd3, 4'd1, 1, 4'd2, 1, 4'd0, 1, 0, "R6 R7");
        // R6 / R7: source A hit on a not-taken transfer
        load(4'd2);
        drive(1, 3'd3, 4'd2, 1, 4'd0, 0, 4'd0, 0, 0, "R6 R7");
        // R8: store, load and unused class as consumers
        load(4'd4);
        drive(1, 3'd5, 4'd4, 1, 4'd4, 1, 4'd0, 0, 0, "R8 store");
        load(4'd4);
        drive(1, 3'd4, 4'd4, 1, 4'd4, 1, 4'd9, 0, 0, "R8 load");
        load(4'd4);
        drive(1, 3'd6, 4'd4, 1, 4'd4, 1, 4'd0, 0, 0, "R8 unused");
        // R9: idle gap keeps the pending record
        load(4'd9);
        idle("R9"); idle("R9"); idle("R9");
        drive(1, 3'd0, 4'd9, 1, 4'd0, 0, 4'd0, 0, 0, "R9");
        // R1: clear zeroes counters and forgets the pending load
        load(4'd9);
        drive(0, 3'd0, 4'd0, 0, 4'd0, 0, 4'd0, 0, 1, "R1 clear");
        drive(1, 3'd0, 4'd9, 1, 4'd0, 0, 4'd0, 0, 0, "R1");
        // R10: drive the narrow instance into saturation
        for (int k = 0; k < 10; k++)
            drive(1, 3'd3, 4'd0, 0, 4'd0, 0, 4'd0, 1, 0, "R10 branch");
        for (int k = 0; k < 5; k++) begin
            load(4'd11);
            drive(1, 3'd0, 4'd11, 1, 4'd11, 1, 4'd0, 0, 0, "R10 load");
        end
        for (int k = 0; k < 17; k++)
            drive(1, 3'd3, 4'd0, 0, 4'd0, 0, 4'd0, 0, 0, "R10 not taken");
        idle("R9 final");
        repeat (3) @(negedge clk);
        report();
    end
endmodule